// File: doc/BRIEF.md
# Dual Capture Timer with Sync, Trigger and Cascade

Two capture channels, even (index 0) and odd (index 1), each own a free-running timer. A channel's timer can be reset in step with an outside event (sync mode) or kept at zero until an outside event starts it (trigger mode). The event comes from one line of a 32-line source bus. A 5-bit field in the channel's control word picks that line. A rising edge on a channel's capture pin stores the timer value in a capture register and gives a one-cycle event pulse.

When both channels ask for it, the pair forms one 32-bit capture unit. The even timer is the low half and the odd timer is the high half. The even pin captures both halves. Software writes a control word to one channel at a time and reads one back through a small register port. Each source line has a fixed index for each channel. A channel that selects its own index sees that source as permanently inactive.

Top module: `ic_pair`

## Requirements
- R1: Control word layout: bit 8 = cascade request, bit 7 = trigger mode (1 = trigger, 0 = sync), bit 6 = trigger status, bits 4:0 = source select. Bits 15:9 and bit 5 always read 0. The whole word is 0 after reset. `rd_data_o` returns the word of the channel that `rd_ch_i` selects (0 = even, 1 = odd), combinationally.
- R2: In sync mode with no source activity, a timer counts up by one on every clock from 0 after reset and wraps at its maximum.
- R3: In trigger mode with the status bit at 0, the channel's timer reads 0.
- R4: In trigger mode, if the selected source is high on an edge while status is 0, status becomes 1 at that edge and the timer counts from the following edge.
- R5: A write sets or clears the status bit directly. A write wins over a hardware set in the same cycle. Clearing it in trigger mode brings the timer to 0 on the edge after the write.
- R6: In sync mode, an edge at which the selected source is high, having been low at the previous edge, loads the timer with 0.
- R7: A channel whose select equals its own index (even 30, odd 31 by default) treats its source as always low, so no trigger and no sync occur.
- R8: A capture pin high at edge n loads the capture register at edge n+2 with the timer value held just before that edge. The matching bit of `cap_evt_o` is high for exactly the cycle after edge n+2.
- R9: The pair cascades only when both channels have bit 8 set. In that case:
  - the odd timer increments only when the even timer wraps from all ones;
  - the odd timer is cleared and held by the even channel's mode;
  - an even-pin edge loads both capture registers and pulses both event bits;
  - the odd pin is ignored.
- R10: With bit 8 set in only one channel, both channels run independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_ch_i | input | 1 | Channel written (0 even, 1 odd) |
| wr_data_i | input | 16 | Control word write data |
| rd_ch_i | input | 1 | Channel read back |
| rd_data_o | output | 16 | Control word read data |
| src_i | input | 32 | Sync/trigger source lines, clock-synchronous |
| cap_pin_i | input | 2 | Capture pins, asynchronous |
| cap_even_o | output | 16 | Even capture register |
| cap_odd_o | output | 16 | Odd capture register |
| cap_evt_o | output | 2 | Capture event pulses |

## Verification
The assertions assume the following about the inputs:
- `src_i` is already synchronous to the clock.
- Capture pins stay high and low for at least two clocks, so every edge passes the synchronizer.
- Write strobes last one cycle.

The bench changes every input on the falling clock edge and holds each pin level for several cycles. It leaves source lines quiet whenever a channel is expected to count freely. A reference model of the timers, driven from the same inputs, supplies the expected capture values. The model also covers a full 16-bit wrap in cascade mode.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int unsigned CW     = 16;
  localparam int unsigned SEL_W  = 5;
  localparam int unsigned CASC_B = 8;
  localparam int unsigned TMOD_B = 7;
  localparam int unsigned TST_B  = 6;

  typedef struct packed {
    logic             casc;
    logic             tmode;
    logic             tstat;
    logic [SEL_W-1:0] sel;
  } ic_ctrl_t;

  function automatic ic_ctrl_t ctrl_unpack(logic [CW-1:0] w);
    ic_ctrl_t c;
    c.casc  = w[CASC_B];
    c.tmode = w[TMOD_B];
    c.tstat = w[TST_B];
    c.sel   = w[SEL_W-1:0];
    return c;
  endfunction

  function automatic logic [CW-1:0] ctrl_pack(ic_ctrl_t c);
    logic [CW-1:0] w;
    w = '0;
    w[CASC_B]      = c.casc;
    w[TMOD_B]      = c.tmode;
    w[TST_B]       = c.tstat;
    w[SEL_W-1:0]   = c.sel;
    return w;
  endfunction
endpackage

// File: rtl/ic_sync.sv
module ic_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], pin_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/ic_src_sel.sv
module ic_src_sel #(
  parameter int unsigned NSRC    = 32,
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned SELF_ID = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             act_o,
  output logic             rise_o
);
  logic prev_q;

  // self-selection reads as an idle source
  assign act_o  = (sel_i != SEL_W'(SELF_ID)) & src_i[sel_i];
  assign rise_o = act_o & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= act_o;
  end
endmodule

// File: rtl/ic_chan.sv
module ic_chan
  import ic_pkg::*;
#(
  parameter int unsigned TMR_W   = 16,
  parameter int unsigned NSRC    = 32,
  parameter int unsigned SELF_ID = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  ic_ctrl_t         wr_ctrl_i,
  input  logic [NSRC-1:0]  src_i,
  input  logic             cap_pin_i,
  input  logic             slave_i,
  input  logic             m_clr_i,
  input  logic             m_inc_i,
  input  logic             m_cap_i,
  output ic_ctrl_t         ctrl_o,
  output logic [TMR_W-1:0] tmr_o,
  output logic             clr_o,
  output logic             rise_o,
  output logic [TMR_W-1:0] cap_o,
  output logic             evt_o
);
  ic_ctrl_t         ctrl_q;
  logic [TMR_W-1:0] tmr_q, cap_q;
  logic             evt_q;
  logic             src_act, src_rise, pin_rise;
  logic             own_hold, own_clr, hw_set;
  logic             t_clr, t_inc, take;

  ic_src_sel #(.NSRC(NSRC), .SEL_W(SEL_W), .SELF_ID(SELF_ID)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .sel_i  (ctrl_q.sel),
    .act_o  (src_act),
    .rise_o (src_rise)
  );

  ic_sync u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cap_pin_i),
    .rise_o (pin_rise)
  );

  assign own_hold = ctrl_q.tmode & ~ctrl_q.tstat;
  assign own_clr  = own_hold | (~ctrl_q.tmode & src_rise);
  assign hw_set   = ctrl_q.tmode & src_act & ~ctrl_q.tstat;

  assign t_clr = slave_i ? m_clr_i : own_clr;
  assign t_inc = slave_i ? m_inc_i : 1'b1;
  assign take  = slave_i ? m_cap_i : pin_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q <= wr_ctrl_i;
    end else if (hw_set) begin
      ctrl_q.tstat <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tmr_q <= '0;
    else if (t_clr) tmr_q <= '0;
    else if (t_inc) tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= take;
      if (take) cap_q <= tmr_q;
    end
  end

  assign ctrl_o = ctrl_q;
  assign tmr_o  = tmr_q;
  assign clr_o  = own_clr;
  assign rise_o = pin_rise;
  assign cap_o  = cap_q;
  assign evt_o  = evt_q;
endmodule

// File: rtl/ic_pair.sv
module ic_pair
  import ic_pkg::*;
#(
  parameter int unsigned TMR_W   = 16,
  parameter int unsigned NSRC    = 32,
  parameter int unsigned EVEN_ID = 30,
  parameter int unsigned ODD_ID  = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_ch_i,
  input  logic [CW-1:0]    wr_data_i,
  input  logic             rd_ch_i,
  output logic [CW-1:0]    rd_data_o,
  input  logic [NSRC-1:0]  src_i,
  input  logic [1:0]       cap_pin_i,
  output logic [TMR_W-1:0] cap_even_o,
  output logic [TMR_W-1:0] cap_odd_o,
  output logic [1:0]       cap_evt_o
);
  ic_ctrl_t         ctrl_s [2];
  logic [CW-1:0]    ctrl_w [2];
  logic [TMR_W-1:0] tmr_w  [2];
  logic [TMR_W-1:0] cap_w  [2];
  logic [1:0]       clr_w, rise_w, evt_w;
  logic             casc_on, carry;
  ic_ctrl_t         wr_ctrl;
  logic             unused_ok;

  assign wr_ctrl = ctrl_unpack(wr_data_i);
  assign casc_on = ctrl_s[0].casc & ctrl_s[1].casc;
  // high half advances when the low half wraps this edge
  assign carry   = ~clr_w[0] & (&tmr_w[0]);

  for (genvar g = 0; g < 2; g++) begin : g_ch
    localparam logic IDX = 1'(g);
    ic_chan #(
      .TMR_W   (TMR_W),
      .NSRC    (NSRC),
      .SELF_ID (g == 0 ? EVEN_ID : ODD_ID)
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i & (wr_ch_i == IDX)),
      .wr_ctrl_i (wr_ctrl),
      .src_i     (src_i),
      .cap_pin_i (cap_pin_i[g]),
      .slave_i   (IDX & casc_on),
      .m_clr_i   (clr_w[0]),
      .m_inc_i   (carry),
      .m_cap_i   (rise_w[0]),
      .ctrl_o    (ctrl_s[g]),
      .tmr_o     (tmr_w[g]),
      .clr_o     (clr_w[g]),
      .rise_o    (rise_w[g]),
      .cap_o     (cap_w[g]),
      .evt_o     (evt_w[g])
    );
    assign ctrl_w[g] = ctrl_pack(ctrl_s[g]);
  end

  assign rd_data_o  = rd_ch_i ? ctrl_w[1] : ctrl_w[0];
  assign cap_even_o = cap_w[0];
  assign cap_odd_o  = cap_w[1];
  assign cap_evt_o  = evt_w;

  assign unused_ok = ^{wr_data_i[CW-1:CASC_B+1], wr_data_i[SEL_W], clr_w[1], rise_w[1]};
endmodule

// File: rtl/ic_pair_chk.sv
module ic_pair_chk #(
  parameter int unsigned TMR_W  = 16,
  parameter int unsigned ODD_ID = 31
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [15:0]      rd_data_o,
  input logic [1:0]       cap_evt_o,
  input logic [TMR_W-1:0] tmr_e,
  input logic [TMR_W-1:0] tmr_o,
  input logic [15:0]      ctrl_e,
  input logic [15:0]      ctrl_o,
  input logic             casc_on
);
  a_r1_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[15:9] == 7'd0 && !rd_data_o[5]);

  a_r3_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_e[7] && !ctrl_e[6] |=> tmr_e == '0);

  a_r7_self_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[7] && !ctrl_o[6] && ctrl_o[4:0] == 5'(ODD_ID) && !wr_en_i |=> !ctrl_o[6]);

  a_r8_evt_even_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_o[0] |=> !cap_evt_o[0]);

  a_r8_evt_odd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_o[1] |=> !cap_evt_o[1]);

  a_r9_hi_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_on && tmr_e != '1 && !wr_en_i |=> $stable(tmr_o) || tmr_o == '0);
endmodule

bind ic_pair ic_pair_chk #(.TMR_W(TMR_W), .ODD_ID(ODD_ID)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_data_o (rd_data_o),
  .cap_evt_o (cap_evt_o),
  .tmr_e     (tmr_w[0]),
  .tmr_o     (tmr_w[1]),
  .ctrl_e    (ctrl_w[0]),
  .ctrl_o    (ctrl_w[1]),
  .casc_on   (casc_on)
);

// File: tb/test_ic_pair.sv
module test_ic_pair;
  localparam int unsigned SELF0 = 30;
  localparam int unsigned SELF1 = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_ch = 1'b0, rd_ch = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [31:0] src = '0;
  logic [1:0]  cap_pin = '0;
  logic [15:0] cap_e, cap_o;
  logic [1:0]  evt;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string ph = "R2";

  logic [15:0] q_val [2][$];
  string       q_tag [2][$];

  always #2 clk = ~clk;

  ic_pair i_ic_pair (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_data_i(wr_data), .rd_ch_i(rd_ch), .rd_data_o(rd_data),
    .src_i(src), .cap_pin_i(cap_pin), .cap_even_o(cap_e),
    .cap_odd_o(cap_o), .cap_evt_o(evt)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model of the timers, driven from requirements
  logic [15:0] m_tmr [2];
  logic        m_casc [2], m_tmode [2], m_tstat [2], m_prev [2];
  logic [4:0]  m_sel [2];
  logic [2:0]  m_sh [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_tmr[c] = '0; m_casc[c] = 0; m_tmode[c] = 0; m_tstat[c] = 0;
        m_prev[c] = 0; m_sel[c] = '0; m_sh[c] = '0;
      end
    end else begin
      logic casc;
      logic act [2];
      logic clr [2];
      logic pr [2];
      logic [15:0] n0, n1;
      casc = m_casc[0] & m_casc[1];
      for (int c = 0; c < 2; c++) begin
        act[c] = src[m_sel[c]] && (m_sel[c] != 5'(c == 0 ? SELF0 : SELF1));
        clr[c] = (m_tmode[c] && !m_tstat[c]) || (!m_tmode[c] && act[c] && !m_prev[c]);
        pr[c]  = m_sh[c][1] && !m_sh[c][2];
      end
      if (pr[0]) begin
        q_val[0].push_back(m_tmr[0]); q_tag[0].push_back(ph);
        if (casc) begin q_val[1].push_back(m_tmr[1]); q_tag[1].push_back(ph); end
      end
      if (!casc && pr[1]) begin q_val[1].push_back(m_tmr[1]); q_tag[1].push_back(ph); end
      n0 = clr[0] ? 16'd0 : m_tmr[0] + 16'd1;
      if (casc) n1 = clr[0] ? 16'd0 : (m_tmr[0] == 16'hFFFF ? m_tmr[1] + 16'd1 : m_tmr[1]);
      else      n1 = clr[1] ? 16'd0 : m_tmr[1] + 16'd1;
      m_tmr[0] = n0; m_tmr[1] = n1;
      for (int c = 0; c < 2; c++) begin
        if (wr_en && wr_ch == 1'(c)) begin
          m_casc[c] = wr_data[8]; m_tmode[c] = wr_data[7];
          m_tstat[c] = wr_data[6]; m_sel[c] = wr_data[4:0];
        end else if (m_tmode[c] && act[c] && !m_tstat[c]) m_tstat[c] = 1;
        m_prev[c] = act[c];
        m_sh[c] = {m_sh[c][1:0], cap_pin[c]};
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (evt[c]) begin
          if (q_val[c].size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL %s: unexpected capture on ch%0d actual %h expected none",
                     ph, c, c == 0 ? cap_e : cap_o);
          end else begin
            string t;
            logic [15:0] v;
            v = q_val[c].pop_front(); t = q_tag[c].pop_front();
            check(t, c == 0 ? cap_e : cap_o, v);
          end
        end
      end
    end
  end

  task automatic wr(logic ch, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_ch = ch; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic ch, logic [15:0] exp);
    @(negedge clk); rd_ch = ch; #1;
    check(req, rd_data, exp);
  endtask

  task automatic pulse(int c);
    @(negedge clk); cap_pin[c] = 1;
    repeat (3) @(negedge clk);
    cap_pin[c] = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(190000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_chk("R1 reset even", 0, 16'h0000);
    rd_chk("R1 reset odd", 1, 16'h0000);

    ph = "R2"; repeat (17) @(negedge clk);
    pulse(0); pulse(1);

    wr(1, 16'hFFFF);
    rd_chk("R1 mask", 1, 16'h01DF);
    wr(1, 16'h0000);
    rd_chk("R1 clear", 1, 16'h0000);

    ph = "R3"; wr(0, 16'h0083);
    repeat (10) @(negedge clk);
    pulse(0);
    rd_chk("R3 status low", 0, 16'h0083);
    ph = "R4";
    @(negedge clk); src[3] = 1;
    repeat (5) @(negedge clk); src[3] = 0;
    rd_chk("R4 status set", 0, 16'h00C3);
    repeat (9) @(negedge clk);
    pulse(0);

    ph = "R5"; wr(0, 16'h0083);
    rd_chk("R5 sw clear", 0, 16'h0083);
    pulse(0);
    wr(0, 16'h00C3);
    repeat (6) @(negedge clk);
    pulse(0);

    ph = "R6"; wr(0, 16'h0004);
    repeat (20) @(negedge clk);
    src[4] = 1;
    repeat (7) @(negedge clk);
    pulse(0);
    src[4] = 0;
    pulse(1);

    ph = "R7"; wr(1, 16'h009F);
    src = '1;
    repeat (6) @(negedge clk);
    rd_chk("R7 self no trigger", 1, 16'h009F);
    pulse(1);
    src = '0;
    wr(1, 16'h0000);

    ph = "R10"; wr(0, 16'h0100);
    repeat (5) @(negedge clk);
    pulse(1); pulse(0);

    ph = "R9"; wr(0, 16'h0180);
    wr(1, 16'h0100);
    wr(0, 16'h01C0);
    repeat (40) @(negedge clk);
    pulse(0);
    pulse(1);
    repeat (65536) @(negedge clk);
    pulse(0);

    repeat (5) @(negedge clk);
    check("R8 queue even drained", 16'(q_val[0].size()), 16'd0);
    check("R8 queue odd drained", 16'(q_val[1].size()), 16'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule